// File: doc/BRIEF.md
# Per-Channel Input Conditioning Bank

This block sits between sixteen asynchronous external signals and a programmable logic fabric. Every channel has its own 3-bit mode code, and software may change that code while the bank runs. The code selects how the raw signal is presented to the fabric:

- resynchronized through a two-flop chain;
- passed straight through with no register;
- turned into a one-cycle pulse on each rising edge;
- turned into a one-cycle pulse on each falling edge.

Codes outside the defined set fall back to the synchronized behaviour. All registered outputs run in the fabric clock domain.

Each channel is built from three pieces:

- A synchronizer chain samples the pin.
- A two-state level tracker holds the edge history. It is in state `TRK_LOW` or `TRK_HIGH`. The transition `GO_HIGH` fires when the synchronized level is 1 in `TRK_LOW`, and `GO_LOW` fires when the level is 0 in `TRK_HIGH`. The tracker acts as the third register stage.
- A selector decodes the mode into one of `BEH_SYNC`, `BEH_BYPASS`, `BEH_RISE` or `BEH_FALL` and drives the output.

The synchronizer and the tracker run in every mode. Changing a channel's mode therefore never loses or invents edge history.

Top module: `inpc_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released with inputs held low, every channel not in bypass (code 001) drives 0. No edge pulse appears.
- R2: Code 000 (synchronized) makes `cond_out[i]` equal the value of `raw_in[i]` sampled two rising clock edges earlier.
- R3: Code 001 (bypass) makes `cond_out[i]` equal `raw_in[i]` combinationally in the same cycle.
- R4: Code 010 (rising edge) makes `cond_out[i]` high for exactly the cycle in which the sample from two edges earlier is 1 and the sample from three edges earlier is 0. Every such pulse lasts one cycle.
- R5: Code 011 (falling edge) makes `cond_out[i]` high for exactly the cycle in which the sample from two edges earlier is 0 and the sample from three edges earlier is 1. Every such pulse lasts one cycle.
- R6: Codes 100 through 111 behave exactly like code 000.
- R7: Edge history is kept across mode changes. Switching a channel with a steady input into an edge mode produces no pulse.
- R8: Channels are independent. Channel i's output depends only on `raw_in[i]` and the code in `mode_cfg[3*i+2:3*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all history stages |
| raw_in | input | 16 | Asynchronous external signals, one per channel |
| mode_cfg | input | 48 | Per-channel 3-bit mode codes; channel i at bits 3*i+2..3*i |
| cond_out | output | 16 | Conditioned signals to the fabric |

## Verification
The hardest case to reach is a mode change that lands while an edge is still inside the three-stage history. Only then do preserved history (R7) and the edge-pulse rules interact. Random stimulus alone rarely lines up a code switch with a transition two edges back, so directed steps provide these cases:

- a switch into rising-edge mode on a long-steady high input;
- a switch made exactly while a fresh edge is in flight.

A random phase then reassigns every channel's code, reserved codes included, every twenty cycles while the inputs toggle.

// File: rtl/inpc_pkg.sv
package inpc_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] CODE_SYNC   = 3'b000;
    localparam logic [MODE_W-1:0] CODE_BYPASS = 3'b001;
    localparam logic [MODE_W-1:0] CODE_RISE   = 3'b010;
    localparam logic [MODE_W-1:0] CODE_FALL   = 3'b011;

    // Behaviour selected for one channel.
    typedef enum logic [1:0] {
        BEH_SYNC   = 2'd0,
        BEH_BYPASS = 2'd1,
        BEH_RISE   = 2'd2,
        BEH_FALL   = 2'd3
    } beh_e;

    // Level tracker states (third history stage).
    typedef enum logic {
        TRK_LOW  = 1'b0,
        TRK_HIGH = 1'b1
    } trk_e;

    // Reserved codes fall back to the synchronized behaviour.
    function automatic beh_e decode_mode(input logic [MODE_W-1:0] code);
        beh_e b;
        case (code)
            CODE_BYPASS: b = BEH_BYPASS;
            CODE_RISE:   b = BEH_RISE;
            CODE_FALL:   b = BEH_FALL;
            default:     b = BEH_SYNC;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/inpc_sync.sv
module inpc_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[DEPTH-2:0], din};
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/inpc_track.sv
module inpc_track
    import inpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise_pls,
    output logic fall_pls
);
    trk_e state_q, state_d;

    // Transition selection: GO_HIGH and GO_LOW.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_LOW:  if (lvl)  state_d = TRK_HIGH;   // GO_HIGH
            TRK_HIGH: if (!lvl) state_d = TRK_LOW;    // GO_LOW
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: a pulse is visible while a transition is pending.
    always_comb begin
        rise_pls = 1'b0;
        fall_pls = 1'b0;
        unique case (state_q)
            TRK_LOW:  rise_pls = lvl;
            TRK_HIGH: fall_pls = !lvl;
        endcase
    end
endmodule

// File: rtl/inpc_select.sv
module inpc_select
    import inpc_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    input  logic              raw,
    input  logic              lvl,
    input  logic              rise_pls,
    input  logic              fall_pls,
    output logic              dout
);
    beh_e beh;

    always_comb begin
        beh = decode_mode(code);
        dout = 1'b0;
        unique case (beh)
            BEH_SYNC:   dout = lvl;
            BEH_BYPASS: dout = raw;
            BEH_RISE:   dout = rise_pls;
            BEH_FALL:   dout = fall_pls;
        endcase
    end
endmodule

// File: rtl/inpc_bank.sv
module inpc_bank
    import inpc_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        raw_in,
    input  logic [NUM_CH*MODE_W-1:0] mode_cfg,
    output logic [NUM_CH-1:0]        cond_out
);
    localparam int CFG_W = NUM_CH * MODE_W;

    logic [NUM_CH-1:0] lvl;
    logic [NUM_CH-1:0] rise_pls;
    logic [NUM_CH-1:0] fall_pls;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [MODE_W-1:0] code;
        assign code = mode_cfg[i*MODE_W +: MODE_W];

        inpc_sync #(.DEPTH(SYNC_DEPTH)) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[i]),
            .dout  (lvl[i])
        );

        inpc_track track_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl[i]),
            .rise_pls (rise_pls[i]),
            .fall_pls (fall_pls[i])
        );

        inpc_select select_i (
            .code     (code),
            .raw      (raw_in[i]),
            .lvl      (lvl[i]),
            .rise_pls (rise_pls[i]),
            .fall_pls (fall_pls[i]),
            .dout     (cond_out[i])
        );
    end

    if (CFG_W != $bits(mode_cfg)) begin : g_bad_cfg
        $error("mode_cfg width mismatch");
    end
endmodule

// File: rtl/inpc_bank_chk.sv
module inpc_bank_chk
    import inpc_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        raw_in,
    input logic [NUM_CH*MODE_W-1:0] mode_cfg,
    input logic [NUM_CH-1:0]        cond_out
);
    // Edges since reset release, saturating at 3.
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic [MODE_W-1:0] c;
        assign c = mode_cfg[i*MODE_W +: MODE_W];

        assert_reset_quiet_R1: assert property (@(posedge clk)
            (!rst_n && c != CODE_BYPASS) |-> !cond_out[i]);

        assert_sync_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2 && c == CODE_SYNC) |-> cond_out[i] == $past(raw_in[i], 2));

        assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (c == CODE_BYPASS) |-> cond_out[i] == raw_in[i]);

        assert_rise_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3 && c == CODE_RISE && cond_out[i])
            |-> ($past(raw_in[i], 2) && !$past(raw_in[i], 3)));

        assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (c == CODE_RISE && cond_out[i])
            |=> (mode_cfg[i*MODE_W +: MODE_W] != CODE_RISE || !cond_out[i]));

        assert_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3 && c == CODE_FALL && cond_out[i])
            |-> (!$past(raw_in[i], 2) && $past(raw_in[i], 3)));

        assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (c == CODE_FALL && cond_out[i])
            |=> (mode_cfg[i*MODE_W +: MODE_W] != CODE_FALL || !cond_out[i]));

        assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2 && c[2]) |-> cond_out[i] == $past(raw_in[i], 2));
    end
endmodule

bind inpc_bank inpc_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw_in),
    .mode_cfg (mode_cfg),
    .cond_out (cond_out)
);

// File: tb/inpc_bank_tb_top.sv
module inpc_bank_tb_top;
    localparam int NCH = 16;
    localparam int MW  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  raw_in = '0;
    logic [NCH*MW-1:0] mode_cfg = '0;
    logic [NCH-1:0]  cond_out;

    // Bench history of samples taken at rising edges since reset.
    logic [NCH-1:0] h1 = '0, h2 = '0, h3 = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    inpc_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (raw_in),
        .mode_cfg (mode_cfg),
        .cond_out (cond_out)
    );

    function automatic logic exp_bit(input logic [2:0] code, input logic r,
                                     input logic s2, input logic s3);
        case (code)
            3'b001:  return r;              // R3
            3'b010:  return s2 & ~s3;       // R4
            3'b011:  return ~s2 & s3;       // R5
            default: return s2;             // R2, R6
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] code);
        case (code)
            3'b000:  return "R2";
            3'b001:  return "R3";
            3'b010:  return "R4";
            3'b011:  return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_all(input string ctx);
        logic [NCH-1:0] exp;
        for (int i = 0; i < NCH; i++)
            exp[i] = exp_bit(mode_cfg[i*MW +: MW], raw_in[i], h2[i], h3[i]);
        n_chk++;
        if (cond_out !== exp) begin
            n_fail++;
            for (int i = 0; i < NCH; i++) begin
                if (cond_out[i] !== exp[i]) begin
                    $display("FAIL %s/%s ch%0d: actual %b expected %b (bus %h vs %h)",
                             ctx, tag_of(mode_cfg[i*MW +: MW]), i,
                             cond_out[i], exp[i], cond_out, exp);
                    break;
                end
            end
        end
    endtask

    // Apply inputs at the falling edge, clock once, check after the edge.
    task automatic step(input logic [NCH-1:0] r, input logic [NCH*MW-1:0] m,
                        input string ctx);
        @(negedge clk);
        raw_in = r;
        mode_cfg = m;
        #1;
        check_all(ctx);
        @(posedge clk);
        h3 = h2; h2 = h1; h1 = raw_in;
        #2;
        check_all(ctx);
    endtask

    function automatic logic [NCH*MW-1:0] all_code(input logic [2:0] c);
        logic [NCH*MW-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*MW +: MW] = c;
        return v;
    endfunction

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [NCH*MW-1:0] m;
        logic [NCH-1:0] r;
        void'($urandom(32'd20240611));

        // R1: reset state with mixed modes (no bypass), inputs low.
        mode_cfg = all_code(3'b010);
        mode_cfg[MW-1:0] = 3'b000;
        mode_cfg[2*MW-1:MW] = 3'b011;
        repeat (3) @(posedge clk);
        #2;
        n_chk++;
        if (cond_out !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: actual %h expected 0000", cond_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after release with inputs low, no pulse.
        for (int k = 0; k < 4; k++) step('0, mode_cfg, "R1");

        // R2 / R3 / R4 / R5 directed: a single pulse train on all channels per mode.
        for (int c = 0; c < 4; c++) begin
            m = all_code(c[2:0]);
            step('0, m, "R2-R5 setup");
            step('1, m, "edge up");
            for (int k = 0; k < 4; k++) step('1, m, "hold high");
            step('0, m, "edge down");
            for (int k = 0; k < 4; k++) step('0, m, "hold low");
        end

        // R6: reserved codes act as synchronized.
        for (int c = 4; c < 8; c++) begin
            m = all_code(c[2:0]);
            step(16'hA5C3, m, "R6");
            step(16'h5A3C, m, "R6");
            step(16'h0000, m, "R6");
            step(16'h0000, m, "R6");
        end

        // R7: steady high input, switch sync -> rising edge: no pulse.
        m = all_code(3'b000);
        for (int k = 0; k < 5; k++) step('1, m, "R7 settle");
        m = all_code(3'b010);
        for (int k = 0; k < 3; k++) step('1, m, "R7 no pulse");
        // R7: switch into falling mode while a real falling edge is in flight.
        m = all_code(3'b000);
        step('0, m, "R7 edge launch");
        m = all_code(3'b011);
        for (int k = 0; k < 3; k++) step('0, m, "R7 kept edge");

        // R8: random mixed codes per channel, reassigned every 20 cycles.
        r = '0;
        for (int k = 0; k < 800; k++) begin
            if (k % 20 == 0)
                for (int i = 0; i < NCH; i++) m[i*MW +: MW] = 3'($urandom_range(0, 7));
            for (int i = 0; i < NCH; i++)
                if ($urandom_range(0, 3) == 0) r[i] = ~r[i];
            step(r, m, "R8 random");
        end

        done = 1;
        report();
    end
endmodule